// File: doc/BRIEF.md
# Prioritized DSP Interrupt Controller

This block sits beside a DSP core and decides which interrupt the core takes next. It collects up to sixteen maskable request lines into a pending-flag register. It gates them with an enable mask and a global disable bit, and picks the winner by fixed priority. A non-maskable request and software-trap requests bypass the global disable and are served ahead of all maskable work.

For each interrupt taken, the core receives a one-cycle take pulse, the 5-bit vector number and the program address of the vector. The address is the table pointer shifted left by seven, plus the vector number shifted left by two. This gives 32 slots of four words each. Once the core has fetched the vector it returns an acknowledge, which clears the pending flag of the maskable source being served. A return input re-enables interrupts when the service routine ends.

A hardware reset and a software reset are distinguished. Only the hardware reset reloads the table pointer. A small register port lets software read the flags, mask, global disable and table pointer, and write them.

Top module: `dsp_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the flag and mask registers read 0, the global disable reads 1, the table pointer reads 0x1FF and `take` is 0.
- R2: A 1 on `irq_in[i]` sets flag bit i at the next clock edge, whatever the mask and global disable hold.
- R3: A maskable source i is taken only when its flag and mask bits are both 1 and the global disable is 0. Among such sources the lowest index wins. Its vector number is IRQ_VEC_BASE + i (default 16 + i), and `take` rises one edge after the flag is visible.
- R4: When no interrupt is in flight, `trap_req` is taken at the next edge with vector `trap_vec`, even when the global disable is 1. It outranks the non-maskable request. A trap requested while an interrupt is in flight is dropped.
- R5: A pulse on `nmi_req` is held pending and is taken with vector NMI_VEC (default 2) once nothing is in flight. It is not gated by the global disable and it outranks every maskable source.
- R6: `take_addr` equals table pointer × 128 + vector × 4, so the default pointer places the table at 0xFF80.
- R7: `take` is high for exactly one cycle. After a take, no further take occurs until `ack` has been sampled high. The earliest following take comes one edge after the edge that sampled `ack`.
- R8: The `ack` for a maskable interrupt clears that source's flag bit. A new request on the same line in the same cycle keeps the bit set.
- R9: Writing select 0 clears every flag bit whose data bit is 1 (write-one-to-clear). A request on the same line in the same cycle keeps the bit set.
- R10: Taking any interrupt sets the global disable to 1. `reti` clears it. A write to select 2 loads it from data bit 0, and the order of precedence is take, then write, then `reti`.
- R11: A `sw_rst` pulse clears the flags, drops a pending non-maskable request and any in-flight interrupt, and sets the global disable to 1. It wins over every other input in that cycle and leaves the mask and the table pointer unchanged.
- R12: The register selects are: 0 flags (bits 15:0), 1 mask (bits 15:0), 2 global disable (bit 0), and 3 table pointer (bits 8:0). Unused read bits are 0, and writes to select 3 take data bits 8:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset pulse |
| irq_in | input | 16 | Maskable request lines |
| nmi_req | input | 1 | Non-maskable request pulse |
| trap_req | input | 1 | Software trap request |
| trap_vec | input | 5 | Vector number of the trap |
| ack | input | 1 | Vector fetch acknowledge from the core |
| reti | input | 1 | Return from service routine |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data (combinational) |
| take | output | 1 | Take-interrupt pulse |
| take_vec | output | 5 | Vector number of the last take |
| take_addr | output | 16 | Vector fetch address of the last take |

## Verification
The selection logic is exercised with a lone masked request, a request held off only by the global disable, and two simultaneous enabled requests. Together these separate mask gating, global-disable gating and index priority. Non-maskable and trap requests are raised with the global disable set and together with competing maskable or non-maskable work, which shows both the bypass and the trap-over-NMI-over-maskable order. Acknowledge and write-one-to-clear are each driven in the same cycle as a fresh request on the same line, so that a design letting the clear win can be told apart. A pending non-maskable request is killed by a software reset, and a table pointer is reprogrammed before a hardware reset, so that the two resets are seen to differ.

// File: rtl/dsp_irq_ctrl.sv
module dsp_irq_ctrl #(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W = 16,
  parameter int PTR_W = 9,
  parameter int VEC_W = 5,
  parameter logic [PTR_W-1:0] RST_PTR = '1,
  parameter logic [VEC_W-1:0] NMI_VEC = 5'd2,
  parameter logic [VEC_W-1:0] IRQ_VEC_BASE = 5'd16,
  localparam int ADDR_W = PTR_W + VEC_W + 2,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic              nmi_req,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              ack,
  input  logic              reti,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              take,
  output logic [VEC_W-1:0]  take_vec,
  output logic [ADDR_W-1:0] take_addr
);

  logic [NUM_IRQ-1:0] flag_q, mask_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [IDX_W-1:0]   svc_idx_q, sel_idx;
  logic intm_q, busy_q, nmi_q, svc_mask_q;

  wire [NUM_IRQ-1:0] ready = flag_q & mask_q & {NUM_IRQ{~intm_q}};
  wire any_ready = |ready;
  wire launch = !busy_q && (trap_req || nmi_q || any_ready);
  wire nmi_go = launch && !trap_req && nmi_q;
  wire mask_go = launch && !trap_req && !nmi_q;

  wire [NUM_IRQ-1:0] ack_clr = (busy_q && ack && svc_mask_q) ?
                               ({{(NUM_IRQ-1){1'b0}}, 1'b1} << svc_idx_q) : '0;
  wire [NUM_IRQ-1:0] wr_clr  = (wr_en && wr_sel == 2'd0) ? wr_data[NUM_IRQ-1:0] : '0;

  always_comb begin
    sel_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (ready[i]) sel_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= '0;
      mask_q     <= '0;
      ptr_q      <= RST_PTR;
      intm_q     <= 1'b1;
      busy_q     <= 1'b0;
      nmi_q      <= 1'b0;
      take       <= 1'b0;
      take_vec   <= '0;
      svc_mask_q <= 1'b0;
      svc_idx_q  <= '0;
    end else if (sw_rst) begin
      flag_q     <= '0;
      intm_q     <= 1'b1;
      busy_q     <= 1'b0;
      nmi_q      <= 1'b0;
      take       <= 1'b0;
      svc_mask_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~wr_clr & ~ack_clr) | irq_in;
      nmi_q  <= nmi_req | (nmi_q & ~nmi_go);
      take   <= launch;
      if (launch) begin
        take_vec   <= trap_req ? trap_vec :
                      nmi_q    ? NMI_VEC  : IRQ_VEC_BASE + VEC_W'(sel_idx);
        svc_mask_q <= mask_go;
        svc_idx_q  <= sel_idx;
      end
      if (launch)   busy_q <= 1'b1;
      else if (ack) busy_q <= 1'b0;
      if (launch)                          intm_q <= 1'b1;
      else if (wr_en && wr_sel == 2'd2)    intm_q <= wr_data[0];
      else if (reti)                       intm_q <= 1'b0;
      if (wr_en && wr_sel == 2'd1) mask_q <= wr_data[NUM_IRQ-1:0];
      if (wr_en && wr_sel == 2'd3) ptr_q  <= wr_data[PTR_W-1:0];
    end
  end

  assign take_addr = {ptr_q, take_vec, 2'b00};

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = DATA_W'(flag_q);
      2'd1:    rd_data = DATA_W'(mask_q);
      2'd2:    rd_data = DATA_W'(intm_q);
      default: rd_data = DATA_W'(ptr_q);
    endcase
  end

endmodule

// File: rtl/dsp_irq_ctrl_chk.sv
module dsp_irq_ctrl_chk #(
  parameter int NUM_IRQ = 16,
  parameter int VEC_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_rst,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic               trap_req,
  input logic [VEC_W-1:0]   trap_vec,
  input logic               ack,
  input logic               take,
  input logic [VEC_W-1:0]   take_vec,
  input logic [NUM_IRQ-1:0] flag_q,
  input logic               intm_q,
  input logic               busy_q,
  input logic               svc_mask_q
);

  // R7
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ack && !sw_rst |=> !take);

  // R4
  trap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && trap_req && !sw_rst |=> take && take_vec == $past(trap_vec));

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rst |=> (flag_q & $past(irq_in)) == $past(irq_in));

  // R10
  take_intm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> intm_q);

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && svc_mask_q |-> !$past(intm_q));

endmodule

bind dsp_irq_ctrl dsp_irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .irq_in(irq_in),
  .trap_req(trap_req), .trap_vec(trap_vec), .ack(ack), .take(take),
  .take_vec(take_vec), .flag_q(flag_q), .intm_q(intm_q), .busy_q(busy_q),
  .svc_mask_q(svc_mask_q)
);

// File: tb/dsp_irq_ctrl_tb.sv
`timescale 1ns/100ps
module dsp_irq_ctrl_tb;
  logic clk = 0, rst_n = 0, sw_rst = 0, nmi_req = 0, trap_req = 0, ack = 0, reti = 0, wr_en = 0;
  logic [15:0] irq_in = 0, wr_data = 0, rd_data, take_addr;
  logic [4:0] trap_vec = 0, take_vec;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic take;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dsp_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .irq_in(irq_in),
    .nmi_req(nmi_req), .trap_req(trap_req), .trap_vec(trap_vec), .ack(ack), .reti(reti),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .take(take), .take_vec(take_vec), .take_addr(take_addr));

  // behavioural reference
  logic [15:0] m_flag, m_mask;
  logic [8:0] m_ptr;
  logic [4:0] m_vec;
  bit m_intm, m_busy, m_nmi, m_take, m_svcm;
  int m_idx;

  always @(posedge clk) begin
    int pick;
    bit go;
    logic [15:0] nf;
    if (!rst_n) begin
      m_flag = 0; m_mask = 0; m_ptr = 9'h1FF; m_intm = 1; m_busy = 0;
      m_nmi = 0; m_take = 0; m_vec = 0; m_svcm = 0; m_idx = 0;
    end else if (sw_rst) begin
      m_flag = 0; m_intm = 1; m_busy = 0; m_nmi = 0; m_take = 0; m_svcm = 0;
    end else begin
      pick = -1;
      go = 0;
      if (!m_intm)
        for (int i = 0; i < 16; i++)
          if (pick < 0 && m_flag[i] && m_mask[i]) pick = i;
      nf = m_flag;
      if (wr_en && wr_sel == 0) nf = nf & ~wr_data;
      if (m_busy && ack && m_svcm) nf[m_idx] = 1'b0;
      nf = nf | irq_in;
      if (!m_busy) begin
        if (trap_req) begin go = 1; m_vec = trap_vec; m_svcm = 0; end
        else if (m_nmi) begin go = 1; m_vec = 5'd2; m_svcm = 0; m_nmi = 0; end
        else if (pick >= 0) begin go = 1; m_vec = 5'(16 + pick); m_svcm = 1; m_idx = pick; end
      end
      if (nmi_req) m_nmi = 1;
      m_flag = nf;
      m_take = go;
      if (go) m_busy = 1; else if (ack) m_busy = 0;
      if (go) m_intm = 1;
      else if (wr_en && wr_sel == 2) m_intm = wr_data[0];
      else if (reti) m_intm = 0;
      if (wr_en && wr_sel == 1) m_mask = wr_data;
      if (wr_en && wr_sel == 3) m_ptr = wr_data[8:0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] er;
    if (rst_n && !done) begin
      chk("R7 take (model)", take, m_take);
      if (m_take) begin
        chk("R3/R4/R5 vector (model)", take_vec, m_vec);
        chk("R6 address (model)", take_addr, {m_ptr, m_vec, 2'b00});
      end
      case (rd_sel)
        0: er = m_flag;
        1: er = m_mask;
        2: er = {15'd0, m_intm};
        default: er = {7'd0, m_ptr};
      endcase
      chk("R12 read (model)", rd_data, er);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    rd_sel = s; #0.2; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick(); wr_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; repeat (3) @(posedge clk); #1; rst_n = 1; tick();
    // R1 reset state
    rd(0, v); chk("R1 flags", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 intm", v, 1);
    rd(3, v); chk("R1 ptr", v, 16'h01FF);
    chk("R1 take", take, 0);
    // R2 masked request still flags
    irq_in = 16'h0010; tick(); irq_in = 0;
    rd(0, v); chk("R2 flag set", v, 16'h0010);
    tick(); chk("R3 masked not taken", take, 0);
    wr(1, 16'h0010); tick(); chk("R3 intm blocks", take, 0);
    wr(2, 16'h0000); tick();
    chk("R3 taken", take, 1); chk("R3 vec", take_vec, 20); chk("R6 addr", take_addr, 16'hFFD0);
    rd(2, v); chk("R10 intm set on take", v, 1);
    tick(); chk("R7 one-cycle pulse", take, 0);
    trap_req = 1; trap_vec = 7; tick(); trap_req = 0;
    chk("R4 trap dropped while busy", take, 0);
    ack = 1; tick(); ack = 0;
    rd(0, v); chk("R8 ack clears flag", v, 0);
    reti = 1; tick(); reti = 0;
    rd(2, v); chk("R10 reti clears intm", v, 0);
    // R3 priority
    wr(1, 16'hFFFF);
    irq_in = 16'h0014; tick(); irq_in = 0;
    tick(); chk("R3 lowest index wins", take_vec, 18);
    ack = 1; irq_in = 16'h0004; tick(); ack = 0; irq_in = 0;
    rd(0, v); chk("R8 request beats ack clear", v, 16'h0014);
    wr_en = 1; wr_sel = 0; wr_data = 16'h0010; irq_in = 16'h0010; tick(); wr_en = 0; irq_in = 0;
    rd(0, v); chk("R9 request beats w1c", v, 16'h0014);
    wr(0, 16'h0014); rd(0, v); chk("R9 w1c clears", v, 0);
    // R5 NMI over maskable
    reti = 1; tick(); reti = 0;
    nmi_req = 1; irq_in = 16'h0001; tick(); nmi_req = 0; irq_in = 0;
    tick(); chk("R5 nmi first", take_vec, 2); chk("R6 nmi addr", take_addr, 16'hFF88);
    ack = 1; tick(); ack = 0;
    reti = 1; tick(); reti = 0;
    tick(); chk("R3 maskable after nmi", take_vec, 16);
    ack = 1; tick(); ack = 0;
    // R4 trap bypasses intm, beats nmi
    trap_req = 1; trap_vec = 7; nmi_req = 1; tick(); trap_req = 0; nmi_req = 0;
    chk("R4 trap taken", take, 1); chk("R4 trap vec", take_vec, 7);
    ack = 1; tick(); ack = 0;
    tick(); chk("R5 nmi with intm set", take_vec, 2); chk("R5 nmi take", take, 1);
    ack = 1; tick(); ack = 0;
    // R6 reprogrammed pointer
    wr(3, 16'h0012);
    trap_req = 1; trap_vec = 31; tick(); trap_req = 0;
    chk("R6 addr new ptr", take_addr, 16'h097C);
    ack = 1; tick(); ack = 0;
    // R11 software reset
    irq_in = 16'h0008; tick(); irq_in = 0;
    nmi_req = 1; tick(); nmi_req = 0;
    sw_rst = 1; tick(); sw_rst = 0;
    rd(0, v); chk("R11 flags cleared", v, 0);
    rd(1, v); chk("R11 mask kept", v, 16'hFFFF);
    rd(3, v); chk("R11 ptr kept", v, 16'h0012);
    rd(2, v); chk("R11 intm set", v, 1);
    tick(); chk("R11 nmi dropped", take, 0);
    tick(); chk("R11 nmi dropped", take, 0);
    // R1 hardware reset reloads pointer
    rst_n = 0; #1;
    rd(3, v); chk("R1 ptr reload", v, 16'h01FF);
    rd(1, v); chk("R1 mask cleared", v, 0);
    tick(); rst_n = 1; tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule